// File: doc/BRIEF.md
# Hash-Steered Shadow Register File

This block is the operand store of a small in-order core that has been extended with custom instructions. It holds the ordinary general-purpose registers, which are read through two ports and written through one, and next to them a small bank of shadow registers that only the custom-instruction operand path can read. Custom instructions often need more than two source values. The shadow bank supplies the extra values without adding read ports to the main array.

No instruction writes a shadow register directly. Each write-back carries a single copy flag. When the flag is set, the result goes to its destination general register and, on the same clock edge, to the shadow register that a programmable lookup table assigns to that destination index. The table has one entry per general register and is loaded through a small configuration port. Software can therefore choose a new mapping for each application, and several general registers can share one shadow slot. Custom logic selects shadow registers by index on its own read ports and gets their contents combinationally, in the same cycle as the two ordinary read ports.

Top module: `shadow_rf`

## Requirements
- R1: Reset (rstN low) clears every general register and every shadow register to zero and sets every lookup-table entry to shadow slot 0.
- R2: Read ports A and B return the contents of the general register at rdIdxA / rdIdxB combinationally, and register index 0 always reads as zero.
- R3: When wbEn is 1 and wbIdx is nonzero, wbData is stored into general register wbIdx at the rising clock edge. A write-back to index 0 changes no state.
- R4: When wbEn is 1, wbIdx is nonzero and wbCopy is 1, wbData is also stored on that same edge into the shadow slot given by the lookup-table entry for wbIdx.
- R5: Shadow slots change only through R4. A write-back with wbCopy at 0, a write-back to index 0, and a cycle with wbEn at 0 all leave every shadow slot unchanged.
- R6: A configuration write (cfgWe at 1) sets the lookup entry for general register cfgIdx to slot cfgShadow. Several general registers may point to one slot, and the most recent copy into a shared slot wins.
- R7: Shadow contents are visible only on the custom read ports: each port p returns slot xrdIdx[p*SW +: SW] on xrdData[p*DATA_W +: DATA_W]. The general read ports keep returning general-register contents whatever the shadow bank holds.
- R8: No read port bypasses a write. In the cycle of a write-back, reads of the target general register and of the target shadow slot return the old values, and the new value appears after the edge.
- R9: A write-back that copies in the same cycle as a configuration write to the same table entry uses the mapping that was in force before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| wbEn | input | 1 | Write-back valid |
| wbIdx | input | AW | Destination general-register index |
| wbData | input | DATA_W | Write-back result |
| wbCopy | input | 1 | Also copy the result into the mapped shadow slot |
| cfgWe | input | 1 | Lookup-table write enable |
| cfgIdx | input | AW | General-register index whose entry is written |
| cfgShadow | input | SW | Shadow slot assigned to cfgIdx |
| rdIdxA | input | AW | Read port A index |
| rdIdxB | input | AW | Read port B index |
| rdDataA | output | DATA_W | Read port A data |
| rdDataB | output | DATA_W | Read port B data |
| xrdIdx | input | NUM_XRD*SW | Shadow slot index for each custom read port, packed |
| xrdData | output | NUM_XRD*DATA_W | Shadow data for each custom read port, packed |

## Verification
The lookup table has no read port, so its contents can only be seen indirectly: a copy is steered through it and the bench then looks at which shadow slot changed. Two cases are the hardest to reach. One is a configuration write and a copying write-back to the same entry on the same edge, which must use the old mapping. The other is a shared slot hit by two different general registers in turn. The stimulus sets up a known mapping first, then runs a vector table of write-backs, each followed by a read of the slot that should have moved. After that come directed cycles that collide a configuration write with a copy, read a target in the same cycle it is written, and apply a second reset to show that the table returns to slot 0.

// File: rtl/shadow_rf_pkg.sv
package shadow_rf_pkg;
  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic coreWr;    // commit write-back to a general register
    logic shadowWr;  // also copy the result into the mapped shadow slot
    logic mapWr;     // update one lookup-table entry
  } rfStrobe_t;
endpackage

// File: rtl/shadow_rf_ctrl.sv
module shadow_rf_ctrl
  import shadow_rf_pkg::*;
#(
  parameter int NUM_CORE   = 32,
  parameter int NUM_SHADOW = 4,
  parameter int AW         = $clog2(NUM_CORE),
  parameter int SW         = (NUM_SHADOW > 1) ? $clog2(NUM_SHADOW) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wbEn,
  input  logic [AW-1:0] wbIdx,
  input  logic          wbCopy,
  input  logic          cfgWe,
  input  logic [AW-1:0] cfgIdx,
  input  logic [SW-1:0] cfgShadow,
  output rfStrobe_t     strobe,
  output logic [SW-1:0] shadowTgt
);
  localparam logic [SW:0] SHADOW_LIM = (SW+1)'(NUM_SHADOW);

  logic [SW-1:0] hashTbl [NUM_CORE];

  // Lookup table: core index -> shadow slot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CORE; i++) hashTbl[i] <= '0;
    end else if (strobe.mapWr) begin
      hashTbl[cfgIdx] <= cfgShadow;
    end
  end

  always_comb begin
    strobe.coreWr   = wbEn && (wbIdx != '0);
    strobe.shadowWr = wbEn && (wbIdx != '0) && wbCopy;
    strobe.mapWr    = cfgWe && ({1'b0, cfgShadow} < SHADOW_LIM);
    shadowTgt       = hashTbl[wbIdx];
  end
endmodule

// File: rtl/shadow_rf_dp.sv
module shadow_rf_dp
  import shadow_rf_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NUM_CORE   = 32,
  parameter int NUM_SHADOW = 4,
  parameter int NUM_XRD    = 2,
  parameter int AW         = $clog2(NUM_CORE),
  parameter int SW         = (NUM_SHADOW > 1) ? $clog2(NUM_SHADOW) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  rfStrobe_t                 strobe,
  input  logic [AW-1:0]             wbIdx,
  input  logic [DATA_W-1:0]         wbData,
  input  logic [SW-1:0]             shadowTgt,
  input  logic [AW-1:0]             rdIdxA,
  input  logic [AW-1:0]             rdIdxB,
  output logic [DATA_W-1:0]         rdDataA,
  output logic [DATA_W-1:0]         rdDataB,
  input  logic [NUM_XRD*SW-1:0]     xrdIdx,
  output logic [NUM_XRD*DATA_W-1:0] xrdData
);
  localparam logic [SW:0] SHADOW_LIM = (SW+1)'(NUM_SHADOW);

  logic [DATA_W-1:0] coreReg   [NUM_CORE];
  logic [DATA_W-1:0] shadowReg [NUM_SHADOW];

  // General registers; entry 0 is never written and stays zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CORE; i++) coreReg[i] <= '0;
    end else if (strobe.coreWr) begin
      coreReg[wbIdx] <= wbData;
    end
  end

  // Shadow bank, written only as a side effect of a write-back
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SHADOW; i++) shadowReg[i] <= '0;
    end else if (strobe.shadowWr) begin
      shadowReg[shadowTgt] <= wbData;
    end
  end

  assign rdDataA = coreReg[rdIdxA];
  assign rdDataB = coreReg[rdIdxB];

  for (genvar g = 0; g < NUM_XRD; g++) begin : g_xrd
    logic [SW-1:0] sel;
    assign sel = xrdIdx[g*SW +: SW];
    assign xrdData[g*DATA_W +: DATA_W] =
      ({1'b0, sel} < SHADOW_LIM) ? shadowReg[sel] : '0;
  end
endmodule

// File: rtl/shadow_rf.sv
module shadow_rf
  import shadow_rf_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NUM_CORE   = 32,
  parameter int NUM_SHADOW = 4,
  parameter int NUM_XRD    = 2,
  localparam int AW        = $clog2(NUM_CORE),
  localparam int SW        = (NUM_SHADOW > 1) ? $clog2(NUM_SHADOW) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wbEn,
  input  logic [AW-1:0]             wbIdx,
  input  logic [DATA_W-1:0]         wbData,
  input  logic                      wbCopy,
  input  logic                      cfgWe,
  input  logic [AW-1:0]             cfgIdx,
  input  logic [SW-1:0]             cfgShadow,
  input  logic [AW-1:0]             rdIdxA,
  input  logic [AW-1:0]             rdIdxB,
  output logic [DATA_W-1:0]         rdDataA,
  output logic [DATA_W-1:0]         rdDataB,
  input  logic [NUM_XRD*SW-1:0]     xrdIdx,
  output logic [NUM_XRD*DATA_W-1:0] xrdData
);
  rfStrobe_t     strobe;
  logic [SW-1:0] shadowTgt;

  shadow_rf_ctrl #(
    .NUM_CORE(NUM_CORE), .NUM_SHADOW(NUM_SHADOW), .AW(AW), .SW(SW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wbEn(wbEn), .wbIdx(wbIdx), .wbCopy(wbCopy),
    .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgShadow(cfgShadow),
    .strobe(strobe), .shadowTgt(shadowTgt)
  );

  shadow_rf_dp #(
    .DATA_W(DATA_W), .NUM_CORE(NUM_CORE), .NUM_SHADOW(NUM_SHADOW),
    .NUM_XRD(NUM_XRD), .AW(AW), .SW(SW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wbIdx(wbIdx), .wbData(wbData),
    .shadowTgt(shadowTgt), .rdIdxA(rdIdxA), .rdIdxB(rdIdxB),
    .rdDataA(rdDataA), .rdDataB(rdDataB), .xrdIdx(xrdIdx), .xrdData(xrdData)
  );
endmodule

// File: rtl/shadow_rf_chk.sv
module shadow_rf_chk #(
  parameter int DATA_W     = 32,
  parameter int NUM_CORE   = 32,
  parameter int NUM_SHADOW = 4,
  parameter int NUM_XRD    = 2,
  localparam int AW        = $clog2(NUM_CORE),
  localparam int SW        = (NUM_SHADOW > 1) ? $clog2(NUM_SHADOW) : 1
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      wbEn,
  input logic [AW-1:0]             wbIdx,
  input logic [DATA_W-1:0]         wbData,
  input logic                      wbCopy,
  input logic [AW-1:0]             rdIdxA,
  input logic [AW-1:0]             rdIdxB,
  input logic [DATA_W-1:0]         rdDataA,
  input logic [DATA_W-1:0]         rdDataB,
  input logic [NUM_XRD*SW-1:0]     xrdIdx,
  input logic [NUM_XRD*DATA_W-1:0] xrdData
);
  // R2
  zero_read_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdIdxA == '0) |-> (rdDataA == '0));

  // R2
  zero_read_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdIdxB == '0) |-> (rdDataB == '0));

  // R3
  wb_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wbEn && wbIdx != '0) |=>
      (rdIdxA != $past(wbIdx) || rdDataA == $past(wbData)));

  // R5
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wbEn && wbCopy && wbIdx != '0) |=>
      (xrdIdx != $past(xrdIdx) || xrdData == $past(xrdData)));
endmodule

bind shadow_rf shadow_rf_chk #(
  .DATA_W(DATA_W), .NUM_CORE(NUM_CORE), .NUM_SHADOW(NUM_SHADOW), .NUM_XRD(NUM_XRD)
) u_chk (.*);

// File: tb/shadow_rf_bench.sv
module shadow_rf_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 5;
  localparam int SW = 2;
  localparam int NX = 2;
  localparam int NVEC = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wbEn = 1'b0, wbCopy = 1'b0, cfgWe = 1'b0;
  logic [AW-1:0] wbIdx = '0, cfgIdx = '0, rdIdxA = '0, rdIdxB = '0;
  logic [DW-1:0] wbData = '0;
  logic [SW-1:0] cfgShadow = '0;
  logic [NX*SW-1:0] xrdIdx = '0;
  logic [DW-1:0] rdDataA, rdDataB;
  logic [NX*DW-1:0] xrdData;

  int nChecks = 0;
  int nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shadow_rf u_shadow_rf (
    .clk(clk), .rstN(rstN), .wbEn(wbEn), .wbIdx(wbIdx), .wbData(wbData),
    .wbCopy(wbCopy), .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgShadow(cfgShadow),
    .rdIdxA(rdIdxA), .rdIdxB(rdIdxB), .rdDataA(rdDataA), .rdDataB(rdDataB),
    .xrdIdx(xrdIdx), .xrdData(xrdData)
  );

  // Vector: {en, idx, data, copy, xsel, xexp, coreExp}
  // Mapping set before the walk: r1->0, r2->1, r3->2, r4->3, r5->1, others 0
  localparam logic [104:0] VEC [NVEC] = '{
    {1'b1, 5'd1, 32'h1111_1111, 1'b1, 2'd0, 32'h1111_1111, 32'h1111_1111}, // R4
    {1'b1, 5'd2, 32'h2222_2222, 1'b0, 2'd1, 32'h0000_0000, 32'h2222_2222}, // R5 copy off
    {1'b1, 5'd2, 32'h3333_3333, 1'b1, 2'd1, 32'h3333_3333, 32'h3333_3333}, // R4
    {1'b1, 5'd5, 32'h5555_5555, 1'b1, 2'd1, 32'h5555_5555, 32'h5555_5555}, // R6 shared slot
    {1'b0, 5'd3, 32'h4444_4444, 1'b1, 2'd2, 32'h0000_0000, 32'h0000_0000}, // R5 no write
    {1'b1, 5'd0, 32'hDEAD_BEEF, 1'b1, 2'd0, 32'h1111_1111, 32'h0000_0000}, // R3 idx 0
    {1'b1, 5'd7, 32'h7777_7777, 1'b1, 2'd0, 32'h7777_7777, 32'h7777_7777}, // R1 default map
    {1'b1, 5'd4, 32'hA5A5_A5A5, 1'b1, 2'd3, 32'hA5A5_A5A5, 32'hA5A5_A5A5}  // R4
  };

  task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic mapEntry(input int idx, input int slot);
    @(negedge clk);
    cfgWe = 1'b1; cfgIdx = AW'(idx); cfgShadow = SW'(slot);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; wbEn = 1'b0; cfgWe = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin : main
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    rdIdxA = 5'd9; rdIdxB = 5'd31; xrdIdx = {2'd3, 2'd0};
    #1;
    check("R1 core A", rdDataA, '0);
    check("R1 core B", rdDataB, '0);
    check("R1 shadow p0", xrdData[DW-1:0], '0);
    check("R1 shadow p1", xrdData[2*DW-1:DW], '0);

    mapEntry(1, 0); mapEntry(2, 1); mapEntry(3, 2); mapEntry(4, 3); mapEntry(5, 1);

    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      wbEn = VEC[v][104]; wbIdx = VEC[v][103:99]; wbData = VEC[v][98:67];
      wbCopy = VEC[v][66];
      @(posedge clk);
      #1;
      wbEn = 1'b0; wbCopy = 1'b0;
      rdIdxA = VEC[v][103:99]; xrdIdx[SW-1:0] = VEC[v][65:64];
      #1;
      check($sformatf("R4/R5 vec %0d shadow", v), xrdData[DW-1:0], VEC[v][63:32]);
      check($sformatf("R3 vec %0d core", v), rdDataA, VEC[v][31:0]);
    end

    // R7: r1 core differs from slot 0, general port still shows core value
    @(negedge clk);
    rdIdxA = 5'd1; rdIdxB = 5'd2; xrdIdx = {2'd1, 2'd0};
    #1;
    check("R7 core r1", rdDataA, 32'h1111_1111);
    check("R7 slot0", xrdData[DW-1:0], 32'h7777_7777);
    check("R2 core B r2", rdDataB, 32'h3333_3333);
    check("R7 slot1 p1", xrdData[2*DW-1:DW], 32'h5555_5555);
    rdIdxB = 5'd0;
    #1;
    check("R2 idx0 B", rdDataB, '0);

    // R8: no bypass within the write cycle
    @(negedge clk);
    wbEn = 1'b1; wbIdx = 5'd6; wbData = 32'h6666_6666; wbCopy = 1'b1;
    rdIdxA = 5'd6; xrdIdx[SW-1:0] = 2'd0;
    #1;
    check("R8 core old", rdDataA, '0);
    check("R8 slot old", xrdData[DW-1:0], 32'h7777_7777);
    @(posedge clk);
    #1;
    wbEn = 1'b0; wbCopy = 1'b0;
    #1;
    check("R8 core new", rdDataA, 32'h6666_6666);
    check("R8 slot new", xrdData[DW-1:0], 32'h6666_6666);

    // R9: config and copy to the same entry on one edge
    @(negedge clk);
    cfgWe = 1'b1; cfgIdx = 5'd8; cfgShadow = 2'd2;
    wbEn = 1'b1; wbIdx = 5'd8; wbData = 32'h8888_8888; wbCopy = 1'b1;
    @(posedge clk);
    #1;
    cfgWe = 1'b0; wbEn = 1'b0; wbCopy = 1'b0;
    xrdIdx = {2'd2, 2'd0};
    #1;
    check("R9 old map slot0", xrdData[DW-1:0], 32'h8888_8888);
    check("R9 slot2 untouched", xrdData[2*DW-1:DW], '0);
    @(negedge clk);
    wbEn = 1'b1; wbIdx = 5'd8; wbData = 32'h9999_9999; wbCopy = 1'b1;
    @(posedge clk);
    #1;
    wbEn = 1'b0; wbCopy = 1'b0;
    #1;
    check("R6 new map slot2", xrdData[2*DW-1:DW], 32'h9999_9999);
    check("R6 slot0 kept", xrdData[DW-1:0], 32'h8888_8888);

    // R1: second reset restores table entry of r8 to slot 0
    doReset();
    #1;
    rdIdxA = 5'd8;
    #1;
    check("R1 core after reset", rdDataA, '0);
    check("R1 slot2 after reset", xrdData[2*DW-1:DW], '0);
    @(negedge clk);
    wbEn = 1'b1; wbIdx = 5'd8; wbData = 32'hC0DE_0008; wbCopy = 1'b1;
    @(posedge clk);
    #1;
    wbEn = 1'b0; wbCopy = 1'b0;
    #1;
    check("R1 map reset slot0", xrdData[DW-1:0], 32'hC0DE_0008);
    check("R1 map reset slot2", xrdData[2*DW-1:DW], '0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule